// File: doc/BRIEF.md
# Nested Exception Priority Arbiter

This block sits beside a small processor core and decides which exception the core should take next. It collects 32 external interrupt lines and five system sources: the non-maskable request, hard fault, supervisor call, pendable service and the periodic tick. Each source keeps a pending bit. The block picks the winner from fixed and programmable priorities and drives the core with a take request, an exception number and a vector table offset. Register stacking, vector fetch, reset sequencing and the bus register file all stay in the core and its surroundings.

The arbiter keeps a stack of the handlers that are currently active. A new take is offered only when a pending source strictly outranks the running handler. The core reports each phase of the exception: it pulses entry start when stacking begins, stacking done when the frame is saved, and return when a handler exits. While stacking is in progress, a higher-priority arrival replaces the selection (late arrival). When a handler returns and a pending source outranks the context below it, the block switches straight to that source (tail chaining) and raises no new stacking request.

Top module: `exc_arbiter`

## Requirements
- R1: Exception numbers are 2 for the non-maskable request, 3 for hard fault, 11 for supervisor call, 14 for pendable service, 15 for the tick and 16+n for external line n. `vec_off_o` is always four times `exc_num_o`. While `take_req_o` is high, `exc_num_o` is one of these numbers.
- R2: A pending bit is set by a rising edge on its source line, or by a set-pending strobe whose `pend_idx_i` equals the exception number. A line that stays high after its exception was taken does not set the bit again.
- R3: A clear-pending strobe at an exception number removes a request that has not yet entered stacking. If the take request was offered for it, that request drops two cycles after the strobe.
- R4: The non-maskable request has priority -2 and hard fault has -1, above every programmable level 0 to 3. Writes to the priority of exception 2 or 3 are ignored. Programmable priorities reset to 0 and are written through `prio_we_i`/`prio_idx_i`/`prio_val_i`. 0 is the highest programmable level.
- R5: When pending sources share a priority level, the lower exception number wins.
- R6: Bit n of `irq_en_i` gates line n out of arbitration without losing its pending bit. The system sources cannot be masked.
- R7: `exec_prio_o` (4-bit two's complement) is the priority of the newest active handler, or 4 when none is active. `take_req_o` rises only for a source whose priority is strictly below (numerically) `exec_prio_o`.
- R8: `take_req_o` stays high with its number until the cycle after a `stack_done_i` pulse that follows `entry_start_i`. That pulse clears the pending bit, pushes the exception and lowers `take_req_o`. The new `exec_prio_o` is strictly higher in rank than the previous one.
- R9: Between `entry_start_i` and `stack_done_i`, a source that becomes pending with strictly higher priority than the current selection replaces it on `exc_num_o`/`vec_off_o` one cycle after its bit sets.
- R10: If, on `exc_ret_i`, a pending source strictly outranks the context being returned to, then the next cycle `tail_chain_o` is high for one cycle. `exc_num_o` shows the new exception, that exception becomes the top handler with its pending bit cleared, and `take_req_o` stays low.
- R11: An `exc_ret_i` without tail chaining pops the top handler, and `exec_prio_o` returns to the level of the handler below, or to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | External interrupt lines |
| nmi_i | input | 1 | Non-maskable request line |
| hardfault_i | input | 1 | Hard fault line |
| svc_i | input | 1 | Supervisor call line |
| pendsv_i | input | 1 | Pendable service line |
| tick_i | input | 1 | Periodic tick line |
| irq_en_i | input | 32 | Per-line enable mask |
| prio_we_i | input | 1 | Priority write strobe |
| prio_idx_i | input | 6 | Exception number to write |
| prio_val_i | input | 2 | Priority level written |
| set_pend_i | input | 1 | Software set-pending strobe |
| clr_pend_i | input | 1 | Software clear-pending strobe |
| pend_idx_i | input | 6 | Exception number for set/clear |
| entry_start_i | input | 1 | Core began stacking |
| stack_done_i | input | 1 | Core finished stacking |
| exc_ret_i | input | 1 | Core executed exception return |
| take_req_o | output | 1 | Take request to the core |
| exc_num_o | output | 6 | Selected exception number |
| vec_off_o | output | 8 | Vector table byte offset |
| tail_chain_o | output | 1 | One-cycle direct switch to a new handler |
| exec_prio_o | output | 4 | Current execution priority, signed |

## Verification
A corrupt active stack shows up on `exec_prio_o` as soon as the push or pop completes. It then shows up again on the next return, as a wrong tail-chain decision or a wrong chained number. A lost or stuck pending bit appears two cycles after its stimulus, either as a missing take request or as an extra take request. Wrong phase tracking shows up in late-arrival replacement, because the number changes at the wrong time or fails to change, and in a take request that does not drop one cycle after stacking completes. The random trials drain every eligible source through a chain of returns, so an ordering error shows up at the first handler that comes out of order.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int unsigned PRIO_W   = 2;
  localparam int unsigned N_SYS    = 16;
  localparam int unsigned EXC_NMI  = 2;
  localparam int unsigned EXC_HF   = 3;
  localparam int unsigned EXC_SVC  = 11;
  localparam int unsigned EXC_PSV  = 14;
  localparam int unsigned EXC_TICK = 15;

  typedef logic signed [PRIO_W+1:0] prio_t;
  localparam prio_t PRIO_NMI    = -2;
  localparam prio_t PRIO_HF     = -1;
  localparam prio_t PRIO_THREAD = prio_t'(2**PRIO_W);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_STACK} phase_e;

  function automatic bit is_src(int unsigned n, int unsigned n_exc);
    return (n == EXC_NMI) || (n == EXC_HF) || (n == EXC_SVC) ||
           (n == EXC_PSV) || (n == EXC_TICK) || (n >= N_SYS && n < n_exc);
  endfunction

  function automatic bit is_cfg(int unsigned n, int unsigned n_exc);
    return is_src(n, n_exc) && n != EXC_NMI && n != EXC_HF;
  endfunction
endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
  parameter int unsigned N_EXC = 48,
  parameter int unsigned EXC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXC-1:0] src_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [EXC_W-1:0] idx_i,
  input  logic             take_i,
  input  logic [EXC_W-1:0] take_idx_i,
  output logic [N_EXC-1:0] pend_o
);
  logic [N_EXC-1:0] prev_q;

  for (genvar n = 0; n < N_EXC; n++) begin : g_bit
    localparam logic [EXC_W-1:0] NUM = EXC_W'(n);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[n] <= 1'b0;
        pend_o[n] <= 1'b0;
      end else begin
        prev_q[n] <= src_i[n];
        // new request wins over any clear in the same cycle
        if ((src_i[n] && !prev_q[n]) || (set_i && idx_i == NUM))
          pend_o[n] <= 1'b1;
        else if ((clr_i && idx_i == NUM) || (take_i && take_idx_i == NUM))
          pend_o[n] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_arb_pkg::*;
#(
  parameter int unsigned N_EXC = 48,
  parameter int unsigned EXC_W = 6
) (
  input  logic [N_EXC-1:0] elig_i,
  input  prio_t            prio_i [N_EXC],
  output logic             vld_o,
  output logic [EXC_W-1:0] num_o,
  output prio_t            prio_o
);
  // descending scan with <= leaves the lowest number among equal levels
  always_comb begin
    vld_o  = 1'b0;
    num_o  = '0;
    prio_o = PRIO_THREAD;
    for (int n = N_EXC - 1; n >= 0; n--) begin
      if (elig_i[n] && (!vld_o || prio_i[n] <= prio_o)) begin
        vld_o  = 1'b1;
        num_o  = EXC_W'(n);
        prio_o = prio_i[n];
      end
    end
  end
endmodule

// File: rtl/exc_act_stack.sv
module exc_act_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned EXC_W = 6,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [EXC_W-1:0] num_i,
  output logic [CNT_W-1:0] depth_o,
  output logic [EXC_W-1:0] top_o,
  output logic [EXC_W-1:0] below_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EXC_W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_o <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i && pop_i && depth_o != '0) begin
      ent_q[IDX_W'(depth_o - 1'b1)] <= num_i;  // tail chain: replace top
    end else if (push_i && depth_o < CNT_W'(DEPTH)) begin
      ent_q[IDX_W'(depth_o)] <= num_i;
      depth_o <= depth_o + 1'b1;
    end else if (pop_i && depth_o != '0) begin
      depth_o <= depth_o - 1'b1;
    end
  end

  assign top_o   = ent_q[IDX_W'(depth_o - 1'b1)];
  assign below_o = ent_q[IDX_W'(depth_o - CNT_W'(2))];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned N_EXC = N_SYS + N_IRQ,
  parameter int unsigned EXC_W = $clog2(N_EXC),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic               nmi_i,
  input  logic               hardfault_i,
  input  logic               svc_i,
  input  logic               pendsv_i,
  input  logic               tick_i,
  input  logic [N_IRQ-1:0]   irq_en_i,
  input  logic               prio_we_i,
  input  logic [EXC_W-1:0]   prio_idx_i,
  input  logic [PRIO_W-1:0]  prio_val_i,
  input  logic               set_pend_i,
  input  logic               clr_pend_i,
  input  logic [EXC_W-1:0]   pend_idx_i,
  input  logic               entry_start_i,
  input  logic               stack_done_i,
  input  logic               exc_ret_i,
  output logic               take_req_o,
  output logic [EXC_W-1:0]   exc_num_o,
  output logic [EXC_W+1:0]   vec_off_o,
  output logic               tail_chain_o,
  output logic [PRIO_W+1:0]  exec_prio_o
);
  logic [N_EXC-1:0] src, en_vec, pend;
  prio_t            prio_tab [N_EXC];

  for (genvar n = 0; n < N_EXC; n++) begin : g_exc
    localparam logic [EXC_W-1:0] NUM = EXC_W'(n);
    if (n == EXC_NMI) begin : g_nmi
      assign src[n] = nmi_i;
      assign prio_tab[n] = PRIO_NMI;
    end else if (n == EXC_HF) begin : g_hf
      assign src[n] = hardfault_i;
      assign prio_tab[n] = PRIO_HF;
    end else if (is_cfg(n, N_EXC)) begin : g_cfg
      logic [PRIO_W-1:0] lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= '0;
        else if (prio_we_i && prio_idx_i == NUM) lvl_q <= prio_val_i;
      end
      assign prio_tab[n] = prio_t'({2'b00, lvl_q});
      if (n == EXC_SVC) begin : g_svc
        assign src[n] = svc_i;
      end else if (n == EXC_PSV) begin : g_psv
        assign src[n] = pendsv_i;
      end else if (n == EXC_TICK) begin : g_tick
        assign src[n] = tick_i;
      end else begin : g_irq
        assign src[n] = irq_i[n-N_SYS];
      end
    end else begin : g_rsvd
      assign src[n] = 1'b0;
      assign prio_tab[n] = PRIO_THREAD;
    end
    if (n >= N_SYS) begin : g_en
      assign en_vec[n] = irq_en_i[n-N_SYS];
    end else begin : g_on
      assign en_vec[n] = 1'b1;
    end
  end

  phase_e           st_q;
  logic [EXC_W-1:0] sel_q, best_num, top_num, below_num, take_num;
  logic [CNT_W-1:0] depth;
  logic             best_vld, chain_q, win, ret_ok, chain, done, push;
  prio_t            best_prio, exec_prio, ret_prio;

  exc_prio_sel #(.N_EXC(N_EXC), .EXC_W(EXC_W)) u_sel (
    .elig_i(pend & en_vec), .prio_i(prio_tab),
    .vld_o(best_vld), .num_o(best_num), .prio_o(best_prio)
  );

  assign exec_prio = (depth == '0) ? PRIO_THREAD : prio_tab[top_num];
  assign ret_prio  = (depth > CNT_W'(1)) ? prio_tab[below_num] : PRIO_THREAD;
  assign win       = best_vld && (best_prio < exec_prio) && (depth < CNT_W'(DEPTH));
  assign ret_ok    = exc_ret_i && st_q == ST_IDLE && depth != '0;
  assign chain     = ret_ok && best_vld && (best_prio < ret_prio);
  assign done      = st_q == ST_STACK && stack_done_i;
  assign push      = done || chain;
  assign take_num  = chain ? best_num : sel_q;

  exc_pend_bank #(.N_EXC(N_EXC), .EXC_W(EXC_W)) u_pend (
    .clk_i, .rst_ni, .src_i(src),
    .set_i(set_pend_i && is_src(pend_idx_i, N_EXC)),
    .clr_i(clr_pend_i), .idx_i(pend_idx_i),
    .take_i(push), .take_idx_i(take_num), .pend_o(pend)
  );

  exc_act_stack #(.DEPTH(DEPTH), .EXC_W(EXC_W), .CNT_W(CNT_W)) u_stack (
    .clk_i, .rst_ni, .push_i(push), .pop_i(ret_ok), .num_i(take_num),
    .depth_o(depth), .top_o(top_num), .below_o(below_num)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      chain_q <= 1'b0;
    end else begin
      chain_q <= chain;
      unique case (st_q)
        ST_IDLE: begin
          if (chain) sel_q <= best_num;
          else if (win && !ret_ok) begin
            st_q  <= ST_REQ;
            sel_q <= best_num;
          end
        end
        ST_REQ: begin
          if (!win) st_q <= ST_IDLE;
          else begin
            sel_q <= best_num;
            if (entry_start_i) st_q <= ST_STACK;
          end
        end
        ST_STACK: begin
          if (stack_done_i) st_q <= ST_IDLE;
          else if (best_vld && best_prio < prio_tab[sel_q]) sel_q <= best_num;  // late arrival
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign take_req_o   = st_q != ST_IDLE;
  assign exc_num_o    = sel_q;
  assign vec_off_o    = {sel_q, 2'b00};
  assign tail_chain_o = chain_q;
  assign exec_prio_o  = exec_prio;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
  import exc_arb_pkg::*;
#(
  parameter int unsigned N_EXC = 48,
  parameter int unsigned EXC_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              entry_start_i,
  input logic              stack_done_i,
  input logic              exc_ret_i,
  input logic              take_req_o,
  input logic [EXC_W-1:0]  exc_num_o,
  input logic              tail_chain_o,
  input logic [PRIO_W+1:0] exec_prio_o
);
  logic entered_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) entered_q <= 1'b0;
    else if (!take_req_o) entered_q <= 1'b0;
    else if (entry_start_i) entered_q <= 1'b1;
  end

  p_num_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_req_o |-> is_src(exc_num_o, N_EXC));

  p_nmi_no_preempt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_req_o) |-> $signed($past(exec_prio_o)) != PRIO_NMI);

  p_deeper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entered_q && take_req_o && stack_done_i) |=>
      $signed(exec_prio_o) < $signed($past(exec_prio_o)));

  p_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entered_q && take_req_o && stack_done_i) |=> !take_req_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entered_q && take_req_o && !stack_done_i) |=> take_req_o);

  p_chain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_chain_o |-> ($past(exc_ret_i) && !take_req_o));
endmodule

bind exc_arbiter exc_arbiter_chk #(.N_EXC(N_EXC), .EXC_W(EXC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .entry_start_i(entry_start_i),
  .stack_done_i(stack_done_i), .exc_ret_i(exc_ret_i), .take_req_o(take_req_o),
  .exc_num_o(exc_num_o), .tail_chain_o(tail_chain_o), .exec_prio_o(exec_prio_o)
);

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq = '0, irq_en = '1;
  logic        nmi = 0, hf = 0, svc = 0, psv = 0, tick = 0;
  logic        prio_we = 0, set_pend = 0, clr_pend = 0;
  logic [5:0]  prio_idx = '0, pend_idx = '0;
  logic [1:0]  prio_val = '0;
  logic        entry_start = 0, stack_done = 0, exc_ret = 0;
  logic        take_req, tail_chain;
  logic [5:0]  exc_num;
  logic [7:0]  vec_off;
  logic [3:0]  exec_prio;
  int checks = 0, failures = 0;
  int prio_m [32];
  bit finished = 0;

  always #5 clk = ~clk;

  exc_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi), .hardfault_i(hf),
    .svc_i(svc), .pendsv_i(psv), .tick_i(tick), .irq_en_i(irq_en),
    .prio_we_i(prio_we), .prio_idx_i(prio_idx), .prio_val_i(prio_val),
    .set_pend_i(set_pend), .clr_pend_i(clr_pend), .pend_idx_i(pend_idx),
    .entry_start_i(entry_start), .stack_done_i(stack_done), .exc_ret_i(exc_ret),
    .take_req_o(take_req), .exc_num_o(exc_num), .vec_off_o(vec_off),
    .tail_chain_o(tail_chain), .exec_prio_o(exec_prio)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_sel(string req, int num);
    chk(req, int'(take_req), 1);
    chk(req, int'(exc_num), num);
    chk(req, int'(vec_off), num * 4);
  endtask

  task automatic chk_chain(string req, int num, int prio);
    chk(req, int'(tail_chain), 1);
    chk(req, int'(exc_num), num);
    chk(req, int'(vec_off), num * 4);
    chk(req, int'($signed(exec_prio)), prio);
    chk(req, int'(take_req), 0);
  endtask

  task automatic wr_prio(int n, int v);
    prio_we = 1; prio_idx = 6'(n); prio_val = 2'(v); step(); prio_we = 0;
  endtask
  task automatic sw_set(int n);
    set_pend = 1; pend_idx = 6'(n); step(); set_pend = 0;
  endtask
  task automatic sw_clr(int n);
    clr_pend = 1; pend_idx = 6'(n); step(); clr_pend = 0;
  endtask
  task automatic take();
    entry_start = 1; step(); entry_start = 0;
    stack_done = 1; step(); stack_done = 0;
  endtask
  task automatic ret();
    exc_ret = 1; step(); exc_ret = 0;
  endtask

  // bench model: best enabled line by (priority, line number)
  function automatic int best_of(logic [31:0] p);
    int b = -1;
    for (int i = 0; i < 32; i++)
      if (p[i] && (b < 0 || prio_m[i] < prio_m[b])) b = i;
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lines, en, model;
    int nb;
    void'($urandom(32'h5eed_1234));
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R7 reset take_req", int'(take_req), 0);
    chk("R7 reset exec_prio", int'($signed(exec_prio)), 4);
    chk("R10 reset tail_chain", int'(tail_chain), 0);

    // fixed priorities, fixed-write ignored, tie break, chaining order
    wr_prio(2, 3); wr_prio(16, 0); wr_prio(15, 0);
    nmi = 1; tick = 1; irq[0] = 1; step(); step();
    chk_sel("R4 nmi wins", 2);
    nmi = 0; tick = 0; irq[0] = 0;
    take();
    chk("R8 take_req drops", int'(take_req), 0);
    chk("R8 exec nmi", int'($signed(exec_prio)), -2);
    hf = 1; step(); hf = 0; step();
    chk("R7 no preempt of nmi", int'(take_req), 0);
    ret(); chk_chain("R10 chain hard fault", 3, -1);
    ret(); chk_chain("R5 tick before irq0", 15, 0);
    ret(); chk_chain("R10 chain irq0", 16, 0);
    ret();
    chk("R11 return to thread", int'(tail_chain), 0);
    chk("R11 exec thread", int'($signed(exec_prio)), 4);
    step(); chk("R11 idle", int'(take_req), 0);

    // strict preemption, equal level waits
    wr_prio(21, 1); wr_prio(22, 1); wr_prio(23, 0);
    irq[5] = 1; step(); step();
    chk_sel("R7 irq5", 21);
    take(); chk("R8 exec irq5", int'($signed(exec_prio)), 1);
    irq[6] = 1; step(); step();
    chk("R7 equal waits", int'(take_req), 0);
    irq[7] = 1; step(); step();
    chk_sel("R7 higher preempts", 23);
    take(); chk("R8 nested exec", int'($signed(exec_prio)), 0);
    ret();
    chk("R11 no chain to equal", int'(tail_chain), 0);
    chk("R11 exec back to irq5", int'($signed(exec_prio)), 1);
    step(); chk("R7 still waits", int'(take_req), 0);
    ret(); chk_chain("R10 chain irq6", 22, 1);
    ret(); chk("R11 exec thread", int'($signed(exec_prio)), 4);
    step(); step();
    chk("R2 held level no repend", int'(take_req), 0);
    irq = '0;

    // late arrival during stacking
    wr_prio(26, 3); wr_prio(18, 2);
    irq[10] = 1; step(); step();
    chk_sel("R9 irq10 selected", 26);
    entry_start = 1; step(); entry_start = 0;
    irq[2] = 1; step(); step();
    chk_sel("R9 late arrival replaces", 18);
    stack_done = 1; step(); stack_done = 0;
    chk("R8 exec late", int'($signed(exec_prio)), 2);
    chk("R8 take_req drops", int'(take_req), 0);
    ret(); chk_chain("R10 chain irq10", 26, 3);
    ret(); chk("R11 exec thread", int'($signed(exec_prio)), 4);
    irq = '0;

    // software set and clear
    sw_set(24); step();
    chk_sel("R2 sw set", 24);
    sw_clr(24); step();
    chk("R3 sw clear drops request", int'(take_req), 0);
    step(); chk("R3 stays clear", int'(take_req), 0);
    sw_set(14); step();
    chk_sel("R1 pendable service", 14);
    take(); ret();
    chk("R11 exec thread", int'($signed(exec_prio)), 4);

    // enable mask
    irq_en[4] = 0; irq[4] = 1; step(); step();
    chk("R6 masked", int'(take_req), 0);
    irq_en[4] = 1; step();
    chk_sel("R6 enabled later", 20);
    take(); ret(); step(); step();
    chk("R2 no repend after take", int'(take_req), 0);
    irq = '0;

    // random trials
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < 32; i++) begin
        prio_m[i] = int'($urandom_range(0, 3));
        wr_prio(16 + i, prio_m[i]);
      end
      lines = $urandom & $urandom;
      en = $urandom | $urandom;
      irq_en = en; irq = lines; step(); step();
      model = lines & en;
      nb = best_of(model);
      if (nb < 0) chk("R6 nothing eligible", int'(take_req), 0);
      else begin
        chk_sel("R5 random first", nb + 16);
        take();
        chk("R8 random exec", int'($signed(exec_prio)), prio_m[nb]);
        model[nb] = 1'b0;
        forever begin
          ret();
          nb = best_of(model);
          if (nb < 0) begin
            chk("R11 random drained", int'(tail_chain), 0);
            chk("R11 random thread", int'($signed(exec_prio)), 4);
            break;
          end
          chk_chain("R10 random chain", nb + 16, prio_m[nb]);
          model[nb] = 1'b0;
        end
      end
      for (int i = 0; i < 32; i++) sw_clr(16 + i);
      irq = '0; irq_en = '1; step(); step();
      chk("R6 masked drained", int'(take_req), 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule